// File: doc/BRIEF.md
# Register Vectorisation Redirection Table

This block sits beside the issue stage. It holds the settings that mark registers as vectors and turns each operand register number of an instruction into the register that issue should really use. Software-visible settings arrive as sixteen configuration slots, each a key-value pair written through a CSR-style port: one word, one slot index and a write strobe. The slots are expanded into two lookup tables, one for the integer file and one for the floating-point file. Each table holds one entry for every architectural register.

For every instruction the issue stage presents up to three operands: a register number, a file select and a valid bit for each. For each operand the block answers with the redirected register number, a vector flag, a 2-bit element width code, a packed-SIMD flag and a bank bit. A single all-scalar flag is also produced, so that issue can send ordinary instructions down the plain scalar path and start the element loop only when some operand is a vector.

Lookups are combinational from registered tables. A slot write reaches the tables one clock after it lands in the slot. A write whose bank bit is set is refused and flagged.

Top module: `svr_redirect`

## Requirements
- R1: After reset both tables are empty. Every operand comes back with its own register number, vector flag 0, width code 0, packed flag 0 and bank 0. The refusal flag is low.
- R2: A configuration word has this layout: bit 0 selects the file (0 integer, 1 floating-point); bits 5:1 give the key register; bits 10:6 give the start register; bits 12:11 give the width code (0 default, 1 half of default, 2 eight bits, 3 sixteen bits); bit 13 is the vector flag; bit 14 is the packed flag; bit 15 is the bank.
- R3: A write with bank = 1 raises the refusal flag for exactly the cycle after the write edge and leaves the addressed slot unchanged. No lookup ever reports bank = 1.
- R4: An operand whose table entry has the vector flag set is answered with that entry's start register, vector flag 1, and the entry's width and packed fields.
- R5: An operand whose entry has the vector flag clear keeps its own register number. The entry's width and packed fields are still reported.
- R6: Integer and floating-point operands look up separate tables. Entries with the same key in different files are independent.
- R7: When several slots name the same file and key, the slot with the highest index decides the entry, even if that slot is not a vector.
- R8: The tables are rebuilt in full from all slots. A slot write sampled on one rising edge changes lookups from the next rising edge on, and not before.
- R9: An entry that no slot names any longer returns to the cleared state once the rebuild completes.
- R10: The all-scalar flag is 1 exactly when no valid operand has its vector flag set. Invalid operands are ignored. With no valid operand the flag is 1.
- R11: The operand outputs follow changes of the operand inputs in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration slot write strobe |
| cfg_idx_i | input | 4 | Slot index |
| cfg_data_i | input | 16 | Configuration word (layout in R2) |
| cfg_reject_o | output | 1 | Previous write refused (bank = 1) |
| op_valid_i | input | 3 | Operand is used by the instruction |
| op_fp_i | input | 3 | Operand file: 0 integer, 1 floating-point |
| op_reg_i | input | 15 | Operand register numbers, 5 bits each, operand 0 lowest |
| op_reg_o | output | 15 | Redirected register numbers |
| op_vec_o | output | 3 | Vector flag per operand |
| op_elw_o | output | 6 | Width code per operand, 2 bits each |
| op_packed_o | output | 3 | Packed-SIMD flag per operand |
| op_bank_o | output | 3 | Bank bit per operand |
| all_scalar_o | output | 1 | No valid operand is a vector |

## Verification
A wrong slot or table entry shows up at the operand ports as soon as that register is looked up. It appears as an unexpected start register, width or packed value, or as a vector flag that disagrees with the all-scalar output. The bench looks up keys that share a register number across the two files, keys written by two slots, and keys that have just been dropped. This way a mixed-up file select, a reversed priority order or a table that is not cleared is visible within the cycle after the rebuild. A refused write is checked through its flag one cycle after the write edge, and through the old lookup result still being present two cycles later.

// File: rtl/svr_pkg.sv
package svr_pkg;

   // Element width codes; the numeric values are part of the slot format.
   typedef enum logic [1:0] {
      ELW_DEFAULT = 2'd0,
      ELW_HALF    = 2'd1,
      ELW_BYTE    = 2'd2,
      ELW_SHORT   = 2'd3
   } svr_elw_e;

   // Per-register attributes, the top five bits of a slot word and of a
   // table entry, in the same order.
   typedef struct packed {
      logic     bank;
      logic     packed_simd;
      logic     is_vec;
      svr_elw_e elw;
   } svr_attr_t;

   localparam int unsigned ATTR_W = $bits(svr_attr_t);

endpackage

// File: rtl/svr_cfg_store.sv
module svr_cfg_store #(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned REG_W       = 5
) (
   input  logic                                   clk_i,
   input  logic                                   rst_ni,
   input  logic                                   we_i,
   input  logic [$clog2(NUM_ENTRIES)-1:0]         idx_i,
   input  logic [2*REG_W+svr_pkg::ATTR_W:0]       data_i,
   output logic [NUM_ENTRIES*(2*REG_W+svr_pkg::ATTR_W+1)-1:0] cfg_o,
   output logic                                   reject_o
);
   localparam int unsigned CFG_W = 2*REG_W + svr_pkg::ATTR_W + 1;
   localparam int unsigned BANK  = CFG_W - 1;

   logic [CFG_W-1:0] slot_q [NUM_ENTRIES];
   logic             reject_q;
   logic             refuse;

   assign refuse = we_i & data_i[BANK];

   generate
      for (genvar s = 0; s < NUM_ENTRIES; s++) begin : g_slot
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               slot_q[s] <= '0;
            else if (we_i && !refuse && (idx_i == s))
               slot_q[s] <= data_i;
         end
         assign cfg_o[s*CFG_W +: CFG_W] = slot_q[s];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) reject_q <= 1'b0;
      else         reject_q <= refuse;
   end
   assign reject_o = reject_q;

   // R3: a refused write is flagged on the following cycle
   p_reject_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && data_i[BANK]) |=> reject_o);

   // R3: a refused write leaves the addressed slot as it was
   p_reject_keeps_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && data_i[BANK] && (idx_i < NUM_ENTRIES))
         |=> (slot_q[$past(idx_i)] == $past(slot_q[idx_i])));

   // R2: an accepted write lands unchanged in its slot
   p_accept_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !data_i[BANK] && (idx_i < NUM_ENTRIES))
         |=> (slot_q[$past(idx_i)] == $past(data_i)));

endmodule

// File: rtl/svr_table_build.sv
module svr_table_build #(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned REG_W       = 5
) (
   input  logic                                                 clk_i,
   input  logic                                                 rst_ni,
   input  logic [NUM_ENTRIES*(2*REG_W+svr_pkg::ATTR_W+1)-1:0]   cfg_i,
   output logic [(2**REG_W)*(REG_W+svr_pkg::ATTR_W)-1:0]        int_tbl_o,
   output logic [(2**REG_W)*(REG_W+svr_pkg::ATTR_W)-1:0]        fp_tbl_o
);
   localparam int unsigned CFG_W    = 2*REG_W + svr_pkg::ATTR_W + 1;
   localparam int unsigned ENT_W    = REG_W + svr_pkg::ATTR_W;
   localparam int unsigned NUM_REGS = 2**REG_W;

   logic [ENT_W-1:0] int_nxt [NUM_REGS];
   logic [ENT_W-1:0] fp_nxt  [NUM_REGS];
   logic [ENT_W-1:0] int_q   [NUM_REGS];
   logic [ENT_W-1:0] fp_q    [NUM_REGS];

   // Full rebuild: clear everything, then apply slots in rising index
   // order so that a later slot overrides an earlier one with the same key.
   always_comb begin
      for (int r = 0; r < NUM_REGS; r++) begin
         int_nxt[r] = '0;
         fp_nxt[r]  = '0;
      end
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         logic [CFG_W-1:0] w;
         w = cfg_i[e*CFG_W +: CFG_W];
         if (!w[CFG_W-1]) begin
            if (w[0]) fp_nxt[w[REG_W:1]]  = w[CFG_W-1:REG_W+1];
            else      int_nxt[w[REG_W:1]] = w[CFG_W-1:REG_W+1];
         end
      end
   end

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               int_q[r] <= '0;
               fp_q[r]  <= '0;
            end else begin
               int_q[r] <= int_nxt[r];
               fp_q[r]  <= fp_nxt[r];
            end
         end
         assign int_tbl_o[r*ENT_W +: ENT_W] = int_q[r];
         assign fp_tbl_o[r*ENT_W +: ENT_W]  = fp_q[r];

         // R3: no stored entry carries the reserved bank value
         p_tbl_bank_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !int_q[r][ENT_W-1] && !fp_q[r][ENT_W-1]);
      end
   endgenerate

endmodule

// File: rtl/svr_operand_lookup.sv
module svr_operand_lookup #(
   parameter int unsigned REG_W = 5
) (
   input  logic                                           fp_i,
   input  logic [REG_W-1:0]                               reg_i,
   input  logic [(2**REG_W)*(REG_W+svr_pkg::ATTR_W)-1:0]  int_tbl_i,
   input  logic [(2**REG_W)*(REG_W+svr_pkg::ATTR_W)-1:0]  fp_tbl_i,
   output logic [REG_W-1:0]                               reg_o,
   output svr_pkg::svr_attr_t                             attr_o
);
   localparam int unsigned ENT_W = REG_W + svr_pkg::ATTR_W;

   logic [ENT_W-1:0]   ent;
   svr_pkg::svr_attr_t attr;

   always_comb begin
      ent    = fp_i ? fp_tbl_i[reg_i*ENT_W +: ENT_W] : int_tbl_i[reg_i*ENT_W +: ENT_W];
      attr   = svr_pkg::svr_attr_t'(ent[ENT_W-1:REG_W]);
      reg_o  = attr.is_vec ? ent[REG_W-1:0] : reg_i;
      attr_o = attr;
   end

endmodule

// File: rtl/svr_redirect.sv
module svr_redirect #(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned REG_W       = 5,
   parameter int unsigned NUM_OPS     = 3
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 cfg_we_i,
   input  logic [$clog2(NUM_ENTRIES)-1:0]       cfg_idx_i,
   input  logic [2*REG_W+svr_pkg::ATTR_W:0]     cfg_data_i,
   output logic                                 cfg_reject_o,
   input  logic [NUM_OPS-1:0]                   op_valid_i,
   input  logic [NUM_OPS-1:0]                   op_fp_i,
   input  logic [NUM_OPS*REG_W-1:0]             op_reg_i,
   output logic [NUM_OPS*REG_W-1:0]             op_reg_o,
   output logic [NUM_OPS-1:0]                   op_vec_o,
   output logic [NUM_OPS*2-1:0]                 op_elw_o,
   output logic [NUM_OPS-1:0]                   op_packed_o,
   output logic [NUM_OPS-1:0]                   op_bank_o,
   output logic                                 all_scalar_o
);
   localparam int unsigned CFG_W    = 2*REG_W + svr_pkg::ATTR_W + 1;
   localparam int unsigned ENT_W    = REG_W + svr_pkg::ATTR_W;
   localparam int unsigned NUM_REGS = 2**REG_W;

   generate
      if (NUM_ENTRIES < 2)        $error("svr_redirect: NUM_ENTRIES must be at least 2");
      if (REG_W < 1 || REG_W > 7) $error("svr_redirect: REG_W out of range 1..7");
      if (NUM_OPS < 1)            $error("svr_redirect: NUM_OPS must be at least 1");
   endgenerate

   logic [NUM_ENTRIES*CFG_W-1:0] cfg;
   logic [NUM_REGS*ENT_W-1:0]    int_tbl;
   logic [NUM_REGS*ENT_W-1:0]    fp_tbl;

   svr_cfg_store #(.NUM_ENTRIES(NUM_ENTRIES), .REG_W(REG_W)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i),
      .idx_i    (cfg_idx_i),
      .data_i   (cfg_data_i),
      .cfg_o    (cfg),
      .reject_o (cfg_reject_o)
   );

   svr_table_build #(.NUM_ENTRIES(NUM_ENTRIES), .REG_W(REG_W)) u_build (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg),
      .int_tbl_o (int_tbl),
      .fp_tbl_o  (fp_tbl)
   );

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         svr_pkg::svr_attr_t attr;

         svr_operand_lookup #(.REG_W(REG_W)) u_look (
            .fp_i      (op_fp_i[g]),
            .reg_i     (op_reg_i[g*REG_W +: REG_W]),
            .int_tbl_i (int_tbl),
            .fp_tbl_i  (fp_tbl),
            .reg_o     (op_reg_o[g*REG_W +: REG_W]),
            .attr_o    (attr)
         );

         assign op_vec_o[g]          = attr.is_vec;
         assign op_elw_o[g*2 +: 2]   = attr.elw;
         assign op_packed_o[g]       = attr.packed_simd;
         assign op_bank_o[g]         = attr.bank;

         // R10: a valid vector operand forbids the scalar path
         p_scalar_blocked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (op_valid_i[g] && op_vec_o[g]) |-> !all_scalar_o);

         // R3: lookups never report the reserved bank
         p_op_bank_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !op_bank_o[g]);

         // R5: a scalar entry never alters the register number
         p_scalar_passthru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !op_vec_o[g] |-> (op_reg_o[g*REG_W +: REG_W] == op_reg_i[g*REG_W +: REG_W]));
      end
   endgenerate

   always_comb all_scalar_o = ~|(op_valid_i & op_vec_o);

   // R10: scalar path refused only when some valid operand is a vector
   p_scalar_reason_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !all_scalar_o |-> ($countones(op_valid_i & op_vec_o) != 0));

endmodule

// File: tb/svr_redirect_tb.sv
`timescale 1ns/1ps
module svr_redirect_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [3:0]  cfg_idx;
   logic [15:0] cfg_data;
   logic        cfg_reject;
   logic [2:0]  op_valid;
   logic [2:0]  op_fp;
   logic [14:0] op_reg;
   logic [14:0] op_reg_o;
   logic [2:0]  op_vec;
   logic [5:0]  op_elw;
   logic [2:0]  op_packed;
   logic [2:0]  op_bank;
   logic        all_scalar;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   svr_redirect u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cfg_we_i     (cfg_we),
      .cfg_idx_i    (cfg_idx),
      .cfg_data_i   (cfg_data),
      .cfg_reject_o (cfg_reject),
      .op_valid_i   (op_valid),
      .op_fp_i      (op_fp),
      .op_reg_i     (op_reg),
      .op_reg_o     (op_reg_o),
      .op_vec_o     (op_vec),
      .op_elw_o     (op_elw),
      .op_packed_o  (op_packed),
      .op_bank_o    (op_bank),
      .all_scalar_o (all_scalar)
   );

   // R2 word layout
   function automatic logic [15:0] mk(input logic fp, input logic [4:0] key,
                                      input logic [4:0] start, input logic [1:0] elw,
                                      input logic vec, input logic pk, input logic bank);
      return {bank, pk, vec, elw, start, key, fp};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [3:0] idx, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // single lookup on operand 0, combinational (R11)
   task automatic look(input logic fp, input logic [4:0] r);
      op_valid = 3'b001; op_fp = {2'b00, fp}; op_reg = {10'd0, r};
      #1;
   endtask

   task automatic expect_op0(input string req, input int r, input int v,
                             input int e, input int p);
      chk({req, " reg"}, op_reg_o[4:0], r);
      chk({req, " vec"}, op_vec[0], v);
      chk({req, " elw"}, op_elw[1:0], e);
      chk({req, " packed"}, op_packed[0], p);
      chk({req, " bank"}, op_bank[0], 0);
   endtask

   // {fp, reg, exp_reg, vec, elw, packed}
   localparam logic [14:0] VEC [8] = '{
      {1'b0, 5'd3,  5'd10, 1'b1, 2'd1, 1'b0},
      {1'b1, 5'd3,  5'd20, 1'b1, 2'd2, 1'b1},
      {1'b0, 5'd5,  5'd5,  1'b0, 2'd3, 1'b1},
      {1'b0, 5'd8,  5'd16, 1'b1, 2'd2, 1'b0},
      {1'b1, 5'd31, 5'd1,  1'b1, 2'd3, 1'b0},
      {1'b0, 5'd31, 5'd31, 1'b0, 2'd0, 1'b0},
      {1'b1, 5'd8,  5'd8,  1'b0, 2'd0, 1'b0},
      {1'b0, 5'd0,  5'd0,  1'b0, 2'd0, 1'b0}
   };

   initial begin
      #1000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
      op_valid = '0; op_fp = '0; op_reg = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: cleared state
      look(1'b0, 5'd3);  expect_op0("R1 int3", 3, 0, 0, 0);
      look(1'b1, 5'd31); expect_op0("R1 fp31", 31, 0, 0, 0);
      chk("R1 all_scalar", all_scalar, 1);
      chk("R1 reject", cfg_reject, 0);

      // R8: write visible only after the rebuild edge
      cfg_write(4'd0, mk(1'b0, 5'd3, 5'd10, 2'd1, 1'b1, 1'b0, 1'b0));
      look(1'b0, 5'd3); expect_op0("R8 before rebuild", 3, 0, 0, 0);
      @(negedge clk);
      look(1'b0, 5'd3); expect_op0("R8 after rebuild", 10, 1, 1, 0);

      cfg_write(4'd1,  mk(1'b1, 5'd3,  5'd20, 2'd2, 1'b1, 1'b1, 1'b0));
      cfg_write(4'd2,  mk(1'b0, 5'd5,  5'd7,  2'd3, 1'b0, 1'b1, 1'b0));
      cfg_write(4'd3,  mk(1'b0, 5'd8,  5'd12, 2'd0, 1'b1, 1'b0, 1'b0));
      cfg_write(4'd9,  mk(1'b0, 5'd8,  5'd16, 2'd2, 1'b1, 1'b0, 1'b0));
      cfg_write(4'd15, mk(1'b1, 5'd31, 5'd1,  2'd3, 1'b1, 1'b0, 1'b0));
      @(negedge clk);

      // R4 R5 R6 R7: table walk
      for (int i = 0; i < 8; i++) begin
         logic [14:0] v;
         v = VEC[i];
         look(v[14], v[13:9]);
         expect_op0($sformatf("R4/R5/R6/R7 vec%0d", i), v[8:4], v[3], v[2:1], v[0]);
      end

      // R3: refused write flagged and slot kept
      cfg_write(4'd0, mk(1'b0, 5'd3, 5'd25, 2'd0, 1'b1, 1'b1, 1'b1));
      chk("R3 reject flag", cfg_reject, 1);
      @(negedge clk);
      chk("R3 reject drops", cfg_reject, 0);
      look(1'b0, 5'd3); expect_op0("R3 slot kept", 10, 1, 1, 0);
      look(1'b0, 5'd25); expect_op0("R3 key untouched", 25, 0, 0, 0);

      // R7: higher slot wins even when it is not a vector
      cfg_write(4'd9, mk(1'b0, 5'd8, 5'd16, 2'd2, 1'b0, 1'b0, 1'b0));
      @(negedge clk);
      look(1'b0, 5'd8); expect_op0("R7 high slot scalar", 8, 0, 2, 0);

      // R9: dropped key returns to cleared state
      cfg_write(4'd2, mk(1'b0, 5'd6, 5'd7, 2'd3, 1'b0, 1'b1, 1'b0));
      @(negedge clk);
      look(1'b0, 5'd5); expect_op0("R9 old key cleared", 5, 0, 0, 0);
      look(1'b0, 5'd6); expect_op0("R9 new key", 6, 0, 3, 1);

      // R10: all-scalar over valid operands; R11 same-cycle response
      op_fp = 3'b000; op_reg = {5'd0, 5'd0, 5'd3};
      op_valid = 3'b011; #1;
      chk("R10 vec op valid", all_scalar, 0);
      chk("R11 op0 redirect", op_reg_o[4:0], 10);
      op_valid = 3'b010; #1;
      chk("R10 vec op ignored", all_scalar, 1);
      op_valid = 3'b000; #1;
      chk("R10 none valid", all_scalar, 1);
      op_fp = 3'b100; op_reg = {5'd3, 5'd0, 5'd0}; op_valid = 3'b100; #1;
      chk("R10 fp op2 vector", all_scalar, 0);
      chk("R6 op2 fp redirect", op_reg_o[14:10], 20);
      chk("R6 op2 elw", op_elw[5:4], 2);
      op_fp = 3'b000; #1;
      chk("R11 op2 file switch", op_reg_o[14:10], 10);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule